// File: doc/BRIEF.md
# System Reset Sequencer with Watchdog and Clock Monitor

This block drives the chip-wide reset and reports which start-up vector software should take once reset is released. Four sources can put the chip into reset: power arriving, the external reset pin, a watchdog that software must keep servicing, and a monitor that catches a stalled system clock.

Power arriving gives a long fixed settle time before release. The pin must stay low long enough to count as a real request. The watchdog advances on the system clock enable through a programmable prescaler. The clock monitor counts an independent reference tick and trips when no system clock enable arrives in time.

The cause output is a two-bit code. Power-up and the external pin share one code, and the watchdog and the clock monitor each have their own. The code stays unchanged until the next reset event.

Top module: `sysreset_ctrl`

## Requirements
- R1: While `pwr_ok` is low, `sys_rst` is high and `rst_cause` is 2'b00. After `pwr_ok` rises it passes through a 2-stage synchronizer. `sys_rst` then stays high for a further POR_CYCLES (default 4064) clock cycles, so it is first low after clock edge POR_CYCLES+2.
- R2: `ext_rst_n` passes through a 2-stage synchronizer. After the synchronizer has shown it low for EXT_MIN (6) consecutive cycles, a reset event occurs with cause 2'b00. `sys_rst` stays high while the pin remains low and for at least HOLD_CYCLES cycles after the event.
- R3: A low pulse on `ext_rst_n` that is shorter than EXT_MIN cycles has no effect on `sys_rst` or `rst_cause`.
- R4: With `cfg_wdog_en` high, a reset event with cause 2'b10 occurs 2^(WD_CNT_BITS+WD_PRE_BITS+s) clock-enable pulses after the last service. The extra prescale s is 0, 1, 2 or 2 for `cfg_wdog_pre` values 0, 1, 2 and 3.
- R5: A cycle with `svc_wr` high and `svc_data` equal to SVC_KEY (default 8'h5A) restarts the watchdog from zero. A write of any other value leaves the timeout unchanged.
- R6: With `cfg_wdog_en` low the watchdog never causes a reset.
- R7: With `cfg_cmon_en` high, CMON_LIMIT consecutive `ref_tick` cycles without any `clk_en` cause a reset event with cause 2'b01. Any `clk_en` pulse restarts the count.
- R8: With `cfg_cmon_en` low, missing `clk_en` pulses never cause a reset.
- R9: When several events land in the same cycle, the reported cause follows this order: power-up, then clock monitor, then watchdog, then external pin.
- R10: A watchdog, clock-monitor or pin event holds `sys_rst` high for exactly HOLD_CYCLES cycles, unless the pin is still low. `rst_cause` keeps its value after release until the next event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running block clock |
| pwr_ok | input | 1 | Power-good level, low forces asynchronous reset |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| clk_en | input | 1 | System clock enable pulse |
| ref_tick | input | 1 | Independent reference tick for the clock monitor |
| cfg_wdog_en | input | 1 | Watchdog enable |
| cfg_wdog_pre | input | 2 | Watchdog extra prescale select |
| cfg_cmon_en | input | 1 | Clock monitor enable |
| svc_wr | input | 1 | Watchdog service write strobe |
| svc_data | input | 8 | Watchdog service write data |
| sys_rst | output | 1 | System reset, active high |
| rst_cause | output | 2 | Vector select: 00 power/pin, 01 clock monitor, 10 watchdog |

## Verification
A watchdog event is due on the clock edge that is exactly 2^(CNT+PRE+s) edges after the service edge. A pin event is due on edge EXT_MIN+2 after the pin falls. A clock-monitor event is due on edge CMON_LIMIT after the enable pulses stop. Power-up release is due on edge POR_CYCLES+2. In every case `sys_rst` is sampled at the falling edge that follows the due edge, and also at the falling edge just before it, so a result one cycle early or one cycle late is reported. Hold length is checked at both its last high edge and its first low edge, and every ignored stimulus is followed by a per-cycle scan of `sys_rst`.

// File: rtl/sysreset_pkg.sv
`timescale 1ns/1ps
package sysreset_pkg;

  typedef enum logic [1:0] {
    CAUSE_POWER  = 2'b00,
    CAUSE_CLKMON = 2'b01,
    CAUSE_WDOG   = 2'b10
  } cause_e;

  localparam int SYNC_STAGES = 2;

endpackage

// File: rtl/sysreset_por.sv
`timescale 1ns/1ps
module sysreset_por #(
  parameter int POR_CYCLES  = 4064,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic pwr_ok,
  output logic por_busy
);

  localparam int CW = $clog2(POR_CYCLES + 1);
  localparam logic [CW-1:0] POR_LAST = CW'(POR_CYCLES);

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic [CW-1:0]          cnt_q, cnt_d;
  logic                   settled;

  assign settled = sync_q[SYNC_STAGES-1];

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], 1'b1};
    cnt_d  = cnt_q;
    if (settled && (cnt_q != POR_LAST)) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge pwr_ok) begin
    if (!pwr_ok) begin
      sync_q <= '0;
      cnt_q  <= '0;
    end else begin
      sync_q <= sync_d;
      cnt_q  <= cnt_d;
    end
  end

  assign por_busy = (cnt_q != POR_LAST);

endmodule

// File: rtl/sysreset_extpin.sv
`timescale 1ns/1ps
module sysreset_extpin #(
  parameter int EXT_MIN     = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic pin_n,
  output logic hit,
  output logic active
);

  localparam int CW = $clog2(EXT_MIN + 1);
  localparam logic [CW-1:0] MIN_V  = CW'(EXT_MIN);
  localparam logic [CW-1:0] PRE_V  = CW'(EXT_MIN - 1);

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic [CW-1:0]          cnt_q, cnt_d;
  logic                   pin_low;

  assign pin_low = !sync_q[SYNC_STAGES-1];

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], pin_n};
    if (!pin_low) begin
      cnt_d = '0;
    end else if (cnt_q != MIN_V) begin
      cnt_d = cnt_q + 1'b1;
    end else begin
      cnt_d = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '1;
      cnt_q  <= '0;
    end else begin
      sync_q <= sync_d;
      cnt_q  <= cnt_d;
    end
  end

  assign hit    = pin_low && (cnt_q == PRE_V);
  assign active = (cnt_q == MIN_V);

endmodule

// File: rtl/sysreset_wdog.sv
`timescale 1ns/1ps
module sysreset_wdog #(
  parameter int          PRE_BITS = 15,
  parameter int          CNT_BITS = 16,
  parameter logic [7:0]  SVC_KEY  = 8'h5A
) (
  input  logic       clk,
  input  logic       arst_n,
  input  logic       en,
  input  logic [1:0] sel,
  input  logic       clk_en,
  input  logic       halt,
  input  logic       svc_wr,
  input  logic [7:0] svc_data,
  output logic       fire
);

  localparam int PW = PRE_BITS + 2;

  logic [PW-1:0]       pre_q, pre_d, mask;
  logic [CNT_BITS-1:0] cnt_q, cnt_d;
  logic [1:0]          shift;
  logic                kick, clear, step, tick;

  always_comb begin
    case (sel)
      2'd0:    shift = 2'd0;
      2'd1:    shift = 2'd1;
      default: shift = 2'd2;
    endcase
    mask  = ~({PW{1'b1}} << (PRE_BITS + int'(shift)));
    kick  = svc_wr && (svc_data == SVC_KEY);
    clear = !en || halt || kick;
    step  = clk_en && en && !halt;
    tick  = step && (&(pre_q | ~mask));
    fire  = tick && (&cnt_q) && !kick;
  end

  always_comb begin
    if (clear || tick) begin
      pre_d = '0;
    end else if (step) begin
      pre_d = pre_q + 1'b1;
    end else begin
      pre_d = pre_q;
    end
    if (clear) begin
      cnt_d = '0;
    end else if (tick) begin
      cnt_d = cnt_q + 1'b1;
    end else begin
      cnt_d = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      pre_q <= pre_d;
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/sysreset_cmon.sv
`timescale 1ns/1ps
module sysreset_cmon #(
  parameter int LIMIT = 64
) (
  input  logic clk,
  input  logic arst_n,
  input  logic en,
  input  logic clk_en,
  input  logic ref_tick,
  input  logic halt,
  output logic fire
);

  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST_V = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          clear;

  always_comb begin
    clear = !en || halt || clk_en;
    fire  = !clear && ref_tick && (cnt_q == LAST_V);
    if (clear) begin
      cnt_d = '0;
    end else if (ref_tick) begin
      cnt_d = cnt_q + 1'b1;
    end else begin
      cnt_d = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/sysreset_ctrl.sv
`timescale 1ns/1ps
module sysreset_ctrl
  import sysreset_pkg::*;
#(
  parameter int         POR_CYCLES  = 4064,
  parameter int         EXT_MIN     = 6,
  parameter int         WD_PRE_BITS = 15,
  parameter int         WD_CNT_BITS = 16,
  parameter int         CMON_LIMIT  = 64,
  parameter int         HOLD_CYCLES = 16,
  parameter logic [7:0] SVC_KEY     = 8'h5A
) (
  input  logic       clk,
  input  logic       pwr_ok,
  input  logic       ext_rst_n,
  input  logic       clk_en,
  input  logic       ref_tick,
  input  logic       cfg_wdog_en,
  input  logic [1:0] cfg_wdog_pre,
  input  logic       cfg_cmon_en,
  input  logic       svc_wr,
  input  logic [7:0] svc_data,
  output logic       sys_rst,
  output logic [1:0] rst_cause
);

  localparam int HW = $clog2(HOLD_CYCLES + 1);
  localparam logic [HW-1:0] HOLD_LD = HW'(HOLD_CYCLES);

  logic          por_busy, ext_hit, ext_active, wd_fire, cmon_fire;
  logic          any_event;
  logic [HW-1:0] hold_q, hold_d;
  cause_e        cause_q, cause_d;

  sysreset_por #(.POR_CYCLES(POR_CYCLES), .SYNC_STAGES(SYNC_STAGES)) u_por (
    .clk      (clk),
    .pwr_ok   (pwr_ok),
    .por_busy (por_busy)
  );

  sysreset_extpin #(.EXT_MIN(EXT_MIN), .SYNC_STAGES(SYNC_STAGES)) u_pin (
    .clk    (clk),
    .arst_n (pwr_ok),
    .pin_n  (ext_rst_n),
    .hit    (ext_hit),
    .active (ext_active)
  );

  sysreset_wdog #(
    .PRE_BITS (WD_PRE_BITS),
    .CNT_BITS (WD_CNT_BITS),
    .SVC_KEY  (SVC_KEY)
  ) u_wdog (
    .clk      (clk),
    .arst_n   (pwr_ok),
    .en       (cfg_wdog_en),
    .sel      (cfg_wdog_pre),
    .clk_en   (clk_en),
    .halt     (sys_rst),
    .svc_wr   (svc_wr),
    .svc_data (svc_data),
    .fire     (wd_fire)
  );

  sysreset_cmon #(.LIMIT(CMON_LIMIT)) u_cmon (
    .clk      (clk),
    .arst_n   (pwr_ok),
    .en       (cfg_cmon_en),
    .clk_en   (clk_en),
    .ref_tick (ref_tick),
    .halt     (sys_rst),
    .fire     (cmon_fire)
  );

  assign any_event = cmon_fire || wd_fire || ext_hit;

  // Cause selection: power-up first, then monitor, watchdog, pin.
  always_comb begin
    if (por_busy) begin
      cause_d = CAUSE_POWER;
    end else if (cmon_fire) begin
      cause_d = CAUSE_CLKMON;
    end else if (wd_fire) begin
      cause_d = CAUSE_WDOG;
    end else if (ext_hit) begin
      cause_d = CAUSE_POWER;
    end else begin
      cause_d = cause_q;
    end
    if (any_event) begin
      hold_d = HOLD_LD;
    end else if (hold_q != '0) begin
      hold_d = hold_q - 1'b1;
    end else begin
      hold_d = hold_q;
    end
  end

  always_ff @(posedge clk or negedge pwr_ok) begin
    if (!pwr_ok) begin
      cause_q <= CAUSE_POWER;
      hold_q  <= '0;
    end else begin
      cause_q <= cause_d;
      hold_q  <= hold_d;
    end
  end

  assign sys_rst   = por_busy || (hold_q != '0) || ext_active;
  assign rst_cause = cause_q;

endmodule

module sysreset_ctrl_chk #(
  parameter logic [7:0] KEY = 8'h5A
) (
  input logic       clk,
  input logic       pwr_ok,
  input logic       sys_rst,
  input logic [1:0] rst_cause,
  input logic       por_busy,
  input logic       wd_fire,
  input logic       cmon_fire,
  input logic       ext_hit,
  input logic       cfg_cmon_en,
  input logic       svc_wr,
  input logic [7:0] svc_data
);

  AST_POR_FORCES_RST: assert property (@(posedge clk) disable iff (!pwr_ok)
    por_busy |-> sys_rst); // R1

  AST_PIN_EVENT_RST: assert property (@(posedge clk) disable iff (!pwr_ok)
    ext_hit |=> sys_rst); // R2

  AST_WDOG_EVENT_RST: assert property (@(posedge clk) disable iff (!pwr_ok)
    (wd_fire && !cmon_fire && !por_busy) |=> (sys_rst && rst_cause == 2'b10)); // R4

  AST_SVC_CANCELS: assert property (@(posedge clk) disable iff (!pwr_ok)
    (svc_wr && svc_data == KEY) |=> !wd_fire); // R5

  AST_CMON_OFF_QUIET: assert property (@(posedge clk) disable iff (!pwr_ok)
    !cfg_cmon_en |-> !cmon_fire); // R8

  AST_CMON_WINS: assert property (@(posedge clk) disable iff (!pwr_ok)
    (cmon_fire && !por_busy) |=> (sys_rst && rst_cause == 2'b01)); // R9

  AST_CAUSE_HELD: assert property (@(posedge clk) disable iff (!pwr_ok)
    (!sys_rst && !$past(sys_rst)) |-> $stable(rst_cause)); // R10

endmodule

bind sysreset_ctrl sysreset_ctrl_chk #(.KEY(SVC_KEY)) u_chk (
  .clk         (clk),
  .pwr_ok      (pwr_ok),
  .sys_rst     (sys_rst),
  .rst_cause   (rst_cause),
  .por_busy    (por_busy),
  .wd_fire     (wd_fire),
  .cmon_fire   (cmon_fire),
  .ext_hit     (ext_hit),
  .cfg_cmon_en (cfg_cmon_en),
  .svc_wr      (svc_wr),
  .svc_data    (svc_data)
);

// File: tb/sysreset_ctrl_tb.sv
`timescale 1ns/1ps
module sysreset_ctrl_tb;

  localparam int         POR  = 4064;
  localparam int         PREB = 2;
  localparam int         CNTB = 3;
  localparam int         CML  = 8;
  localparam int         HOLD = 8;
  localparam logic [7:0] KEY  = 8'h5A;

  // Watchdog vectors: {prescale select, edges from service to reset}
  localparam int NVEC = 4;
  localparam int VEC [NVEC][2] = '{
    '{0, 1 << (PREB + CNTB + 0)},
    '{1, 1 << (PREB + CNTB + 1)},
    '{2, 1 << (PREB + CNTB + 2)},
    '{3, 1 << (PREB + CNTB + 2)}
  };

  logic       clk = 1'b0;
  logic       pwr_ok, ext_rst_n, clk_en, ref_tick;
  logic       cfg_wdog_en, cfg_cmon_en, svc_wr;
  logic [1:0] cfg_wdog_pre;
  logic [7:0] svc_data;
  logic       sys_rst;
  logic [1:0] rst_cause;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  sysreset_ctrl #(
    .POR_CYCLES  (POR),
    .EXT_MIN     (6),
    .WD_PRE_BITS (PREB),
    .WD_CNT_BITS (CNTB),
    .CMON_LIMIT  (CML),
    .HOLD_CYCLES (HOLD),
    .SVC_KEY     (KEY)
  ) u_dut (
    .clk          (clk),
    .pwr_ok       (pwr_ok),
    .ext_rst_n    (ext_rst_n),
    .clk_en       (clk_en),
    .ref_tick     (ref_tick),
    .cfg_wdog_en  (cfg_wdog_en),
    .cfg_wdog_pre (cfg_wdog_pre),
    .cfg_cmon_en  (cfg_cmon_en),
    .svc_wr       (svc_wr),
    .svc_data     (svc_data),
    .sys_rst      (sys_rst),
    .rst_cause    (rst_cause)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic service(input logic [7:0] v);
    svc_wr = 1'b1;
    svc_data = v;
    step(1);
    svc_wr = 1'b0;
    svc_data = 8'h00;
  endtask

  // Counts cycles with sys_rst high over n edges
  task automatic scan(input int n, output int highs);
    highs = 0;
    for (int i = 0; i < n; i++) begin
      step(1);
      if (sys_rst) highs++;
    end
  endtask

  task automatic finish_run;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 60000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected under 60000", cyc);
      finish_run();
    end
  end

  initial begin
    int highs;
    pwr_ok = 1'b0; ext_rst_n = 1'b1; clk_en = 1'b1; ref_tick = 1'b0;
    cfg_wdog_en = 1'b0; cfg_wdog_pre = 2'd0; cfg_cmon_en = 1'b0;
    svc_wr = 1'b0; svc_data = 8'h00;

    // R1: power-up
    step(3);
    chk("R1 rst while power low", sys_rst, 1);
    chk("R1 cause during power low", rst_cause, 0);
    pwr_ok = 1'b1;
    step(POR + 1);
    chk("R1 rst still held", sys_rst, 1);
    step(1);
    chk("R1 rst released", sys_rst, 0);
    chk("R1 cause power", rst_cause, 0);

    // R4/R10: watchdog vector table
    cfg_wdog_en = 1'b1;
    for (int v = 0; v < NVEC; v++) begin
      cfg_wdog_pre = VEC[v][0][1:0];
      service(KEY);
      step(VEC[v][1] - 1);
      chk("R4 wdog not yet", sys_rst, 0);
      step(1);
      chk("R4 wdog reset", sys_rst, 1);
      chk("R4 wdog cause", rst_cause, 2);
      step(HOLD - 1);
      chk("R10 hold last cycle", sys_rst, 1);
      step(1);
      chk("R10 hold released", sys_rst, 0);
      chk("R10 cause kept", rst_cause, 2);
    end

    // R5: wrong key has no effect
    cfg_wdog_pre = 2'd0;
    service(KEY);
    step(18);
    service(KEY ^ 8'hFF);
    step(12);
    chk("R5 wrong key before timeout", sys_rst, 0);
    step(1);
    chk("R5 wrong key timeout kept", sys_rst, 1);
    step(HOLD);
    // R5: right key restarts
    service(KEY);
    step(18);
    service(KEY);
    step(31);
    chk("R5 key restarted count", sys_rst, 0);
    step(1);
    chk("R5 reset after restart", sys_rst, 1);
    step(HOLD);

    // R6: watchdog disabled
    cfg_wdog_en = 1'b0;
    scan(200, highs);
    chk("R6 disabled wdog quiet", highs, 0);

    // R3: short pin pulse
    ext_rst_n = 1'b0;
    step(5);
    ext_rst_n = 1'b1;
    scan(15, highs);
    chk("R3 short pulse ignored", highs, 0);
    chk("R3 cause unchanged", rst_cause, 2);

    // R2: accepted pin pulse
    ext_rst_n = 1'b0;
    step(7);
    chk("R2 pin not yet", sys_rst, 0);
    step(1);
    chk("R2 pin reset", sys_rst, 1);
    chk("R2 pin cause", rst_cause, 0);
    step(2);
    ext_rst_n = 1'b1;
    step(5);
    chk("R10 pin hold last", sys_rst, 1);
    step(1);
    chk("R10 pin hold released", sys_rst, 0);

    // R2: long pin low keeps reset past hold
    ext_rst_n = 1'b0;
    step(25);
    chk("R2 held while pin low", sys_rst, 1);
    step(5);
    ext_rst_n = 1'b1;
    step(2);
    chk("R2 pin release pending", sys_rst, 1);
    step(1);
    chk("R2 pin released", sys_rst, 0);

    // R7: clock monitor
    cfg_cmon_en = 1'b1; clk_en = 1'b0; ref_tick = 1'b1;
    step(7);
    chk("R7 cmon not yet", sys_rst, 0);
    step(1);
    chk("R7 cmon reset", sys_rst, 1);
    chk("R7 cmon cause", rst_cause, 1);
    step(HOLD);
    highs = 0;
    for (int i = 0; i < 40; i++) begin
      clk_en = (i % 5 == 0);
      step(1);
      if (sys_rst) highs++;
    end
    chk("R7 clk_en restarts monitor", highs, 0);

    // R8: monitor disabled
    cfg_cmon_en = 1'b0; clk_en = 1'b0;
    scan(30, highs);
    chk("R8 disabled monitor quiet", highs, 0);

    // R9: monitor and pin in same cycle
    step(HOLD);
    ext_rst_n = 1'b0; cfg_cmon_en = 1'b1;
    step(8);
    chk("R9 both events reset", sys_rst, 1);
    chk("R9 monitor wins", rst_cause, 1);
    ext_rst_n = 1'b1; clk_en = 1'b1; cfg_cmon_en = 1'b0;
    step(20);
    chk("R9 released", sys_rst, 0);

    finish_run();
  end

endmodule